// File: doc/BRIEF.md
# Amplifier Mode Sequencer

This controller sits between the decoded three-level mode request of a two-channel switching audio amplifier and the enables of its power stage and audio path. It runs a timed start-up so that no audible pop reaches the loudspeaker. The power stage starts switching only after a first delay. Audio is released only after a second, longer delay, and only when operation is requested.

Before the stage is first enabled after standby, the block checks every output terminal for a short to either supply rail. While any short is reported, it holds the start-up. Once the stage runs, these short reports are ignored. A fault request from the protection logic drops the stage and the audio. When the fault clears, the block restarts through the same mute timing.

All delays are clock-cycle counts set by parameters. The defaults match a 50 MHz clock: 110 ms to switching, 220 ms to audio and a 100 ms minimum stay before standby.

Top module: `amp_mode_seq`

## Requirements
- R1: Mode request encoding is 2'b00 standby, 2'b01 mute, 2'b10 and 2'b11 operate. While reset is low the block is in standby, with `stage_en` = 0, `audio_on` = 0 and `status` = 0.
- R2: Leaving standby, the block spends one cycle in the output check. If no short is seen it enters mute-delay, and `stage_en` rises exactly SW_DLY cycles after mute-delay is entered.
- R3: `audio_on` rises only while operate is requested, and never earlier than AUD_DLY cycles after mute-delay was entered. A direct standby-to-operate request therefore enables audio exactly AUD_DLY cycles after mute-delay starts.
- R4: While mute is requested, `audio_on` stays 0 and the stage keeps switching. A change from operate to mute drops `audio_on` at the next edge and keeps `stage_en` high.
- R5: If any bit of `short_hi` or `short_lo` is set during the output check, the block waits with the stage off until all bits are clear. On the edge after they clear, it enters mute-delay.
- R6: Short indications have no effect once mute-delay has been entered.
- R7: A standby request is ignored until the block has spent HOLD_MIN cycles out of standby. It is then honoured at that edge.
- R8: An accepted standby request takes the block to standby at the next edge from any state, with stage and audio off. This has priority over a fault. In standby, shorts and faults have no effect.
- R9: A fault request in mute or operate moves the block to mute-delay with stage and audio off, and the delay count stays at zero while the fault persists. After the fault clears, the R2 and R3 timing applies again. A fault in the check or wait states has no effect.
- R10: `status` encodes the state: 0 standby, 1 output check, 2 waiting for a short to clear, 3 mute-delay, 4 mute, 5 operate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_req | input | 2 | Decoded mode request |
| short_hi | input | N_OUT | Per-output short to positive rail |
| short_lo | input | N_OUT | Per-output short to negative rail |
| fault | input | 1 | Shutdown request from protection |
| stage_en | output | 1 | Power stage switching enable |
| audio_on | output | 1 | Audio path unmute |
| status | output | 3 | Current state code |

## Verification
The bench builds the block with SW_DLY = 10, AUD_DLY = 20 and HOLD_MIN = 8, and with N_OUT = 2. These values put the exact edge where switching starts, the edge where audio is released, and the last ignored standby request within a few dozen cycles. They also let the fault restart and the saturated-timer mute-to-operate transition be walked cycle by cycle.

// File: rtl/amp_mode_seq.sv
module amp_mode_seq #(
  parameter int N_OUT    = 2,
  parameter int SW_DLY   = 5_500_000,
  parameter int AUD_DLY  = 11_000_000,
  parameter int HOLD_MIN = 5_000_000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode_req,
  input  logic [N_OUT-1:0] short_hi,
  input  logic [N_OUT-1:0] short_lo,
  input  logic             fault,
  output logic             stage_en,
  output logic             audio_on,
  output logic [2:0]       status
);
  localparam int TW = $clog2(AUD_DLY + 1);
  localparam int HW = $clog2(HOLD_MIN + 1);

  typedef enum logic [2:0] {
    S_STBY = 3'd0, S_TEST = 3'd1, S_WAIT = 3'd2,
    S_MDLY = 3'd3, S_MUTE = 3'd4, S_OPER = 3'd5
  } st_t;

  st_t st, st_nx;
  logic [TW-1:0] tmr;
  logic [HW-1:0] hold;

  wire req_stby  = (mode_req == 2'b00);
  wire req_op    = mode_req[1];
  wire any_short = |{short_hi, short_lo};
  wire hold_ok   = (hold == HW'(HOLD_MIN - 1));
  wire sw_done   = (tmr == TW'(SW_DLY - 1));
  wire aud_ok    = (tmr >= TW'(AUD_DLY - 1));
  wire go_stby   = (st != S_STBY) && req_stby && hold_ok;

  always_comb begin
    st_nx = st;
    if (go_stby) st_nx = S_STBY;
    else begin
      case (st)
        S_STBY:         if (!req_stby) st_nx = S_TEST;
        S_TEST, S_WAIT: st_nx = any_short ? S_WAIT : S_MDLY;
        S_MDLY:         if (!fault && sw_done) st_nx = S_MUTE;
        S_MUTE:         if (fault) st_nx = S_MDLY;
                        else if (req_op && aud_ok) st_nx = S_OPER;
        S_OPER:         if (fault) st_nx = S_MDLY;
                        else if (!req_op) st_nx = S_MUTE;
        default:        st_nx = S_STBY;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) st <= S_STBY;
    else        st <= st_nx;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) tmr <= '0;
    else if (st_nx == S_STBY) tmr <= '0;
    else if (st_nx == S_MDLY && (st != S_MDLY || fault)) tmr <= '0;
    else if ((st == S_MDLY || st == S_MUTE || st == S_OPER) && tmr != TW'(AUD_DLY))
      tmr <= tmr + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) hold <= '0;
    else if (st == S_STBY) hold <= '0;
    else if (!hold_ok) hold <= hold + 1'b1;

  assign stage_en = (st == S_MUTE) || (st == S_OPER);
  assign audio_on = (st == S_OPER);
  assign status   = st;

  a_r2_switch_delay: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stage_en) |-> ($past(st) == S_MDLY && $past(tmr) == TW'(SW_DLY - 1)));
  a_r3_audio_gate: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(audio_on) |-> ($past(req_op) && $past(tmr) >= TW'(AUD_DLY - 1)));
  a_r6_wait_only_startup: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WAIT) |-> ($past(st) == S_TEST || $past(st) == S_WAIT));
  a_r7_stby_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_STBY && $past(st) != S_STBY) |-> $past(hold) == HW'(HOLD_MIN - 1));
  a_r8_stby_kills: assert property (@(posedge clk) disable iff (!rst_n)
    go_stby |=> (!stage_en && !audio_on));
  a_r9_fault_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (fault && !go_stby && (st == S_MUTE || st == S_OPER)) |=> (st == S_MDLY && !stage_en));
endmodule

// File: tb/test_amp_mode_seq.sv
module test_amp_mode_seq;
  localparam int CLK_P = 10;
  localparam int NV = 29;

  logic clk = 1'b0, rst_n = 1'b0, fault = 1'b0;
  logic [1:0] mode_req = 2'b00, short_hi = 2'b00, short_lo = 2'b00;
  logic stage_en, audio_on;
  logic [2:0] status;
  int n_run = 0, n_fail = 0;

  always #(CLK_P/2) clk = ~clk;

  amp_mode_seq #(.N_OUT(2), .SW_DLY(10), .AUD_DLY(20), .HOLD_MIN(8)) i_amp_mode_seq (
    .clk(clk), .rst_n(rst_n), .mode_req(mode_req), .short_hi(short_hi),
    .short_lo(short_lo), .fault(fault), .stage_en(stage_en),
    .audio_on(audio_on), .status(status));

  // {req, hi, lo, fault, edges, exp_stage, exp_audio, exp_status, req_no}
  localparam logic [23:0] VEC [NV] = '{
    {2'd0, 2'd0, 2'd0, 1'b0, 8'd2,  1'b0, 1'b0, 3'd0, 4'd1},  // R1
    {2'd2, 2'd0, 2'd0, 1'b0, 8'd1,  1'b0, 1'b0, 3'd1, 4'd10}, // R10
    {2'd2, 2'd0, 2'd0, 1'b0, 8'd1,  1'b0, 1'b0, 3'd3, 4'd2},  // R2
    {2'd2, 2'd0, 2'd0, 1'b0, 8'd9,  1'b0, 1'b0, 3'd3, 4'd2},  // R2
    {2'd2, 2'd0, 2'd0, 1'b0, 8'd1,  1'b1, 1'b0, 3'd4, 4'd2},  // R2
    {2'd2, 2'd0, 2'd0, 1'b0, 8'd9,  1'b1, 1'b0, 3'd4, 4'd3},  // R3
    {2'd2, 2'd0, 2'd0, 1'b0, 8'd1,  1'b1, 1'b1, 3'd5, 4'd3},  // R3
    {2'd1, 2'd0, 2'd0, 1'b0, 8'd1,  1'b1, 1'b0, 3'd4, 4'd4},  // R4
    {2'd0, 2'd0, 2'd0, 1'b0, 8'd1,  1'b0, 1'b0, 3'd0, 4'd8},  // R8
    {2'd1, 2'd1, 2'd0, 1'b0, 8'd1,  1'b0, 1'b0, 3'd1, 4'd5},  // R5
    {2'd1, 2'd1, 2'd0, 1'b0, 8'd1,  1'b0, 1'b0, 3'd2, 4'd5},  // R5
    {2'd0, 2'd1, 2'd0, 1'b0, 8'd6,  1'b0, 1'b0, 3'd2, 4'd7},  // R7
    {2'd0, 2'd1, 2'd0, 1'b0, 8'd1,  1'b0, 1'b0, 3'd0, 4'd7},  // R7
    {2'd1, 2'd0, 2'd2, 1'b0, 8'd2,  1'b0, 1'b0, 3'd2, 4'd5},  // R5
    {2'd1, 2'd0, 2'd0, 1'b0, 8'd1,  1'b0, 1'b0, 3'd3, 4'd5},  // R5
    {2'd1, 2'd3, 2'd3, 1'b0, 8'd10, 1'b1, 1'b0, 3'd4, 4'd6},  // R6
    {2'd1, 2'd0, 2'd0, 1'b1, 8'd1,  1'b0, 1'b0, 3'd3, 4'd9},  // R9
    {2'd2, 2'd0, 2'd0, 1'b1, 8'd5,  1'b0, 1'b0, 3'd3, 4'd9},  // R9
    {2'd2, 2'd0, 2'd0, 1'b0, 8'd9,  1'b0, 1'b0, 3'd3, 4'd9},  // R9
    {2'd2, 2'd0, 2'd0, 1'b0, 8'd1,  1'b1, 1'b0, 3'd4, 4'd9},  // R9
    {2'd2, 2'd0, 2'd0, 1'b0, 8'd9,  1'b1, 1'b0, 3'd4, 4'd3},  // R3
    {2'd2, 2'd0, 2'd0, 1'b0, 8'd1,  1'b1, 1'b1, 3'd5, 4'd3},  // R3
    {2'd2, 2'd0, 2'd0, 1'b1, 8'd1,  1'b0, 1'b0, 3'd3, 4'd9},  // R9
    {2'd0, 2'd0, 2'd0, 1'b1, 8'd1,  1'b0, 1'b0, 3'd0, 4'd8},  // R8
    {2'd0, 2'd3, 2'd3, 1'b1, 8'd3,  1'b0, 1'b0, 3'd0, 4'd8},  // R8
    {2'd1, 2'd0, 2'd0, 1'b0, 8'd2,  1'b0, 1'b0, 3'd3, 4'd2},  // R2
    {2'd1, 2'd0, 2'd0, 1'b0, 8'd10, 1'b1, 1'b0, 3'd4, 4'd2},  // R2
    {2'd1, 2'd0, 2'd0, 1'b0, 8'd20, 1'b1, 1'b0, 3'd4, 4'd4},  // R4
    {2'd3, 2'd0, 2'd0, 1'b0, 8'd1,  1'b1, 1'b1, 3'd5, 4'd3}   // R3
  };

  task automatic chk(input int rq, input logic es, input logic ea, input logic [2:0] ec);
    n_run++;
    if (stage_en !== es || audio_on !== ea || status !== ec) begin
      n_fail++;
      $display("FAIL R%0d: stage/audio/status got %b/%b/%0d expected %b/%b/%0d",
               rq, stage_en, audio_on, status, es, ea, ec);
    end
  endtask

  task automatic run(input logic [1:0] rq, input logic [1:0] hi, input logic [1:0] lo,
                     input logic f, input int n);
    mode_req = rq; short_hi = hi; short_lo = lo; fault = f;
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(CLK_P * 20000);
    n_fail++;
    $display("FAIL watchdog: run did not end, got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk);
    chk(1, 1'b0, 1'b0, 3'd0);            // R1 during reset
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      run(VEC[i][23:22], VEC[i][21:20], VEC[i][19:18], VEC[i][17], int'(VEC[i][16:9]));
      chk(int'(VEC[i][3:0]), VEC[i][8], VEC[i][7], VEC[i][6:4]);
    end
    // R1: reset in the middle of operate
    rst_n = 1'b0;
    @(negedge clk);
    chk(1, 1'b0, 1'b0, 3'd0);
    mode_req = 2'b00;
    @(negedge clk);
    rst_n = 1'b1;
    // R9: fault during wait has no effect
    run(2'd1, 2'd2, 2'd0, 1'b0, 2);
    chk(5, 1'b0, 1'b0, 3'd2);
    run(2'd1, 2'd2, 2'd0, 1'b1, 2);
    chk(9, 1'b0, 1'b0, 3'd2);
    run(2'd1, 2'd0, 2'd0, 1'b1, 1);
    chk(9, 1'b0, 1'b0, 3'd3);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule